// File: doc/BRIEF.md
# Addressed Serial Message Bus Node

This block is one node on a shared two-wire message bus. An external serial clock steps a phase counter through a fixed frame. A start phase comes first. Next is a 32-edge shifting phase, in which every listening node clocks the shared data line into its own 32-bit shift register. The shifting master also receives its own data this way. A three-phase tail confirms delivery. In the tail, the master first releases the line so that it idles high. The addressed node then pulls the line low as an acknowledge. Finally, on the edge that leaves the acknowledge phase, the master records whether it saw an acknowledge and the receiver flags that a message is waiting.

The data line is treated as open-drain. The node never drives it high. It only asserts a drive-low enable, and the surrounding wiring forms the wired-AND. Both serial inputs are resynchronised to the system clock before use. A small register port gives the processor access to the shift register bytes, a control register, a status register and the current phase code. An interrupt line is raised while either status flag is set.

Top module: `msgbus_node`

## Requirements
- R1: After reset the shift register, control and status registers are zero, the phase code reads 0x01, the drive-low output is low and irq is low.
- R2: In the shifting phase, a node whose deaf bit is clear shifts left on each synchronised rising serial edge, inserting the sampled line level at bit 0. The first bit received lands in bit 31 after 32 edges.
- R3: The phase code runs 0x01 (start) → 0x02 (32 rising edges) → 0x10 → 0x20 → 0x40 → 0x01, advancing only on rising serial edges. It is readable at register address 6.
- R4: A node with its master bit set asserts drive-low in phases 0x01 and 0x02 exactly when shift register bit 31 is 0. No node drives the line in phases 0x10 and 0x40.
- R5: In phase 0x20 a node asserts drive-low exactly when its deaf bit is clear and shift register bits 31..29 equal its 3-bit bus address.
- R6: On the rising edge that leaves phase 0x20, a master sets the not-acknowledged flag if the sampled line is high and clears it if the line is low.
- R7: On that same edge, a node that is not deaf and whose address matches sets the read-pending flag.
- R8: A processor read of register address 3 (the most significant byte) clears read-pending in the following cycle.
- R9: irq equals the OR of not-acknowledged and read-pending. Writing a 1 to status bit 0 clears not-acknowledged.
- R10: A node with its deaf bit set keeps its shift register unchanged through a frame and does not acknowledge.
- R11: Both serial inputs pass through a two-flop synchroniser. A serial rising edge changes registered state on the third system clock edge after the input rises.
- R12: Register map: addresses 0..3 hold shift register bytes from least to most significant. Address 4 is control, with bit 4 master, bit 3 deaf and bits 2..0 bus address. Address 5 is status, with bit 1 read-pending and bit 0 not-acknowledged. Address 6 is the phase code. Reads are combinational and writes take effect on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClkIn | input | 1 | Shared serial clock, asynchronous |
| serDatIn | input | 1 | Level of the shared data line, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| serDatDriveLow | output | 1 | Open-drain enable: pulls the data line low |
| irq | output | 1 | Interrupt request |

## Verification
Every serial edge takes effect on the third system clock edge after the input rises: two edges pass through the synchroniser and the third updates the registered state. Drive-low and irq then follow combinationally from that state. The bench model pushes both serial inputs through a three-entry history queue and steps its state at each rising clock, so every expected value falls due in the same cycle as the design's. Outputs are compared on each falling edge, and register reads are checked in the same cycle that the read is presented, before the edge that may clear read-pending.

// File: rtl/msgbus_pkg.sv
package msgbus_pkg;

  typedef enum logic [7:0] {
    PH_START   = 8'h01,
    PH_SHIFT   = 8'h02,
    PH_RELEASE = 8'h10,
    PH_ACK     = 8'h20,
    PH_REPORT  = 8'h40
  } phase_e;

  typedef struct packed {
    logic shiftNow;     // rising serial edge inside the shifting phase
    logic dataWindow;   // master may put message bits on the line
    logic ackWindow;    // acknowledge phase
    logic quietWindow;  // line must be released by everyone
    logic reportNow;    // rising serial edge that leaves the acknowledge phase
    logic lineLevel;    // synchronised data line level
  } strobe_t;

endpackage

// File: rtl/msgbus_ctrl.sv
module msgbus_ctrl
  import msgbus_pkg::*;
#(
  parameter int SHIFT_BITS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClkIn,
  input  logic    serDatIn,
  output strobe_t strobes,
  output phase_e  phase
);
  localparam int CW = $clog2(SHIFT_BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(SHIFT_BITS - 1);

  logic [SYNC_STAGES:0]   clkPipe;
  logic [SYNC_STAGES-1:0] datPipe;
  logic [CW-1:0]          bitCnt;
  logic                   serRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      datPipe <= '0;
    end else begin
      clkPipe <= {clkPipe[SYNC_STAGES-1:0], serClkIn};
      datPipe <= {datPipe[SYNC_STAGES-2:0], serDatIn};
    end
  end

  assign serRise = clkPipe[SYNC_STAGES-1] & ~clkPipe[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_START;
      bitCnt <= '0;
    end else if (serRise) begin
      case (phase)
        PH_START: begin
          phase  <= PH_SHIFT;
          bitCnt <= '0;
        end
        PH_SHIFT: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) phase <= PH_RELEASE;
        end
        PH_RELEASE: phase <= PH_ACK;
        PH_ACK:     phase <= PH_REPORT;
        default:    phase <= PH_START;
      endcase
    end
  end

  always_comb begin
    strobes.shiftNow    = serRise && (phase == PH_SHIFT);
    strobes.dataWindow  = (phase == PH_START) || (phase == PH_SHIFT);
    strobes.ackWindow   = (phase == PH_ACK);
    strobes.quietWindow = (phase == PH_RELEASE) || (phase == PH_REPORT);
    strobes.reportNow   = serRise && (phase == PH_ACK);
    strobes.lineLevel   = datPipe[SYNC_STAGES-1];
  end

  // R3: the phase only moves on a serial rising edge
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !serRise |=> $stable(phase));
  // R3: release is followed by acknowledge
  a_r3_release_to_ack: assert property (@(posedge clk) disable iff (!rstN)
    (serRise && phase == PH_RELEASE) |=> phase == PH_ACK);
  // R3: report wraps back to the start phase
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (serRise && phase == PH_REPORT) |=> phase == PH_START);

endmodule

// File: rtl/msgbus_dp.sv
module msgbus_dp
  import msgbus_pkg::*;
#(
  parameter int SHIFT_BITS    = 32,
  parameter int ADDR_BITS     = 3,
  parameter int REG_ADDR_BITS = 3,
  parameter int DATA_BITS     = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobes,
  input  phase_e                   phase,
  input  logic                     regWrEn,
  input  logic                     regRdEn,
  input  logic [REG_ADDR_BITS-1:0] regAddr,
  input  logic [DATA_BITS-1:0]     regWrData,
  output logic [DATA_BITS-1:0]     regRdData,
  output logic                     driveLow,
  output logic                     irq
);
  localparam int NBYTES = SHIFT_BITS / DATA_BITS;
  localparam logic [REG_ADDR_BITS-1:0] MSB_ADDR   = REG_ADDR_BITS'(NBYTES - 1);
  localparam logic [REG_ADDR_BITS-1:0] CTRL_ADDR  = REG_ADDR_BITS'(NBYTES);
  localparam logic [REG_ADDR_BITS-1:0] STAT_ADDR  = REG_ADDR_BITS'(NBYTES + 1);
  localparam logic [REG_ADDR_BITS-1:0] PHASE_ADDR = REG_ADDR_BITS'(NBYTES + 2);

  logic [SHIFT_BITS-1:0] sr, srNext;
  logic [ADDR_BITS-1:0]  busAddr;
  logic                  deaf, master, nack, readPending;
  logic                  matched, srWr;
  logic [DATA_BITS-1:0]  srByte [NBYTES];

  genvar g;
  for (g = 0; g < NBYTES; g++) begin : g_byte
    assign srByte[g] = sr[g*DATA_BITS +: DATA_BITS];
  end

  assign matched = !deaf && (sr[SHIFT_BITS-1 -: ADDR_BITS] == busAddr);
  assign srWr    = regWrEn && (regAddr < CTRL_ADDR);

  always_comb begin
    srNext = sr;
    if (strobes.shiftNow && !deaf) srNext = {sr[SHIFT_BITS-2:0], strobes.lineLevel};
    for (int b = 0; b < NBYTES; b++)
      if (regWrEn && regAddr == REG_ADDR_BITS'(b)) srNext[b*DATA_BITS +: DATA_BITS] = regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr          <= '0;
      busAddr     <= '0;
      deaf        <= 1'b0;
      master      <= 1'b0;
      nack        <= 1'b0;
      readPending <= 1'b0;
    end else begin
      sr <= srNext;
      if (regWrEn && regAddr == CTRL_ADDR) begin
        busAddr <= regWrData[ADDR_BITS-1:0];
        deaf    <= regWrData[ADDR_BITS];
        master  <= regWrData[ADDR_BITS+1];
      end
      if (strobes.reportNow && master)              nack <= strobes.lineLevel;
      else if (regWrEn && regAddr == STAT_ADDR && regWrData[0]) nack <= 1'b0;
      if (strobes.reportNow && matched)              readPending <= 1'b1;
      else if (regRdEn && regAddr == MSB_ADDR)       readPending <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    for (int b = 0; b < NBYTES; b++)
      if (regAddr == REG_ADDR_BITS'(b)) regRdData = srByte[b];
    if (regAddr == CTRL_ADDR) begin
      regRdData[ADDR_BITS-1:0] = busAddr;
      regRdData[ADDR_BITS]     = deaf;
      regRdData[ADDR_BITS+1]   = master;
    end
    if (regAddr == STAT_ADDR) regRdData[1:0] = {readPending, nack};
    if (regAddr == PHASE_ADDR) regRdData = DATA_BITS'(phase);
  end

  assign driveLow = (master && strobes.dataWindow && !sr[SHIFT_BITS-1])
                  || (strobes.ackWindow && matched);
  assign irq      = nack | readPending;

  // R4: released line in the quiet phases
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strobes.quietWindow |-> !driveLow);
  // R5: a deaf node never acknowledges
  a_r5_deaf_silent: assert property (@(posedge clk) disable iff (!rstN)
    (deaf && strobes.ackWindow) |-> !driveLow);
  // R6: master records the sampled acknowledge level
  a_r6_nack_capture: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.reportNow && master) |=> (nack == $past(strobes.lineLevel)));
  // R7: addressed listener raises read-pending
  a_r7_pending_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.reportNow && matched) |=> readPending);
  // R8: reading the top byte clears read-pending
  a_r8_pending_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == MSB_ADDR && !(strobes.reportNow && matched)) |=> !readPending);
  // R10: deaf node keeps its shift register
  a_r10_deaf_hold: assert property (@(posedge clk) disable iff (!rstN)
    (deaf && !srWr) |=> $stable(sr));

endmodule

// File: rtl/msgbus_node.sv
module msgbus_node
  import msgbus_pkg::*;
#(
  parameter int SHIFT_BITS    = 32,
  parameter int ADDR_BITS     = 3,
  parameter int REG_ADDR_BITS = 3,
  parameter int DATA_BITS     = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serClkIn,
  input  logic                     serDatIn,
  input  logic                     regWrEn,
  input  logic                     regRdEn,
  input  logic [REG_ADDR_BITS-1:0] regAddr,
  input  logic [DATA_BITS-1:0]     regWrData,
  output logic [DATA_BITS-1:0]     regRdData,
  output logic                     serDatDriveLow,
  output logic                     irq
);
  strobe_t strobes;
  phase_e  phase;

  msgbus_ctrl #(
    .SHIFT_BITS (SHIFT_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .serClkIn (serClkIn),
    .serDatIn (serDatIn),
    .strobes  (strobes),
    .phase    (phase)
  );

  msgbus_dp #(
    .SHIFT_BITS   (SHIFT_BITS),
    .ADDR_BITS    (ADDR_BITS),
    .REG_ADDR_BITS(REG_ADDR_BITS),
    .DATA_BITS    (DATA_BITS)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .phase     (phase),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .driveLow  (serDatDriveLow),
    .irq       (irq)
  );

endmodule

// File: tb/test_msgbus_node.sv
module test_msgbus_node;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SER   = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serClk = 1'b0;
  logic       peerLow = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       dutLow, irq, lineIn;

  int checks = 0, fails = 0;

  assign lineIn = !(dutLow | peerLow);

  always #(CLK_PERIOD/2) clk = ~clk;

  msgbus_node i_msgbus_node (
    .clk(clk), .rstN(rstN), .serClkIn(serClk), .serDatIn(lineIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .serDatDriveLow(dutLow), .irq(irq));

  // ---------------- behavioural reference model ----------------
  logic [7:0]  mPhase;
  int          mCnt;
  logic [31:0] mSr;
  logic [2:0]  mAddr;
  logic        mDeaf, mMaster, mNack, mRp;
  logic        qc[$], qd[$];

  function automatic logic mMatched();
    return !mDeaf && (mSr[31:29] == mAddr);
  endfunction

  function automatic logic expDrive();
    return (mMaster && (mPhase == 8'h01 || mPhase == 8'h02) && !mSr[31])
        || (mPhase == 8'h20 && mMatched());
  endfunction

  function automatic logic [7:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mSr[7:0];
      3'd1: return mSr[15:8];
      3'd2: return mSr[23:16];
      3'd3: return mSr[31:24];
      3'd4: return {3'b000, mMaster, mDeaf, mAddr};
      3'd5: return {6'b0, mRp, mNack};
      3'd6: return mPhase;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 8'h01; mCnt = 0; mSr = '0; mAddr = '0;
      mDeaf = 0; mMaster = 0; mNack = 0; mRp = 0;
      qc = '{1'b0, 1'b0, 1'b0};
      qd = '{1'b0, 1'b0, 1'b0};
    end else begin
      logic rise, lev, match;
      logic [31:0] nSr;
      logic [7:0]  nPhase;
      logic nNack, nRp;
      rise  = qc[1] && !qc[0];   // R11: two-flop sync plus edge detect
      lev   = qd[1];
      match = mMatched();
      nSr = mSr;
      if (rise && mPhase == 8'h02 && !mDeaf) nSr = {mSr[30:0], lev};
      if (regWrEn && regAddr < 3'd4) nSr[regAddr*8 +: 8] = regWrData;
      nNack = mNack;
      if (rise && mPhase == 8'h20 && mMaster) nNack = lev;
      else if (regWrEn && regAddr == 3'd5 && regWrData[0]) nNack = 0;
      nRp = mRp;
      if (rise && mPhase == 8'h20 && match) nRp = 1;
      else if (regRdEn && regAddr == 3'd3) nRp = 0;
      nPhase = mPhase;
      if (rise) begin
        case (mPhase)
          8'h01: begin nPhase = 8'h02; mCnt = 0; end
          8'h02: begin mCnt++; if (mCnt == 32) nPhase = 8'h10; end
          8'h10: nPhase = 8'h20;
          8'h20: nPhase = 8'h40;
          default: nPhase = 8'h01;
        endcase
      end
      if (regWrEn && regAddr == 3'd4) begin
        mAddr = regWrData[2:0]; mDeaf = regWrData[3]; mMaster = regWrData[4];
      end
      mSr = nSr; mNack = nNack; mRp = nRp; mPhase = nPhase;
      void'(qc.pop_front()); qc.push_back(serClk);
      void'(qd.pop_front()); qd.push_back(lineIn);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      string tag;
      tag = (mPhase == 8'h20) ? "R5" : "R4";
      checks++;
      if (dutLow !== expDrive()) begin
        fails++;
        $display("FAIL %s R11 drive-low phase %h: got %b expected %b", tag, mPhase, dutLow, expDrive());
      end
      checks++;
      if (irq !== (mNack | mRp)) begin
        fails++;
        $display("FAIL R9 irq: got %b expected %b", irq, mNack | mRp);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic regRead(input logic [2:0] a, input string req);
    @(negedge clk); #1;
    regRdEn = 1; regAddr = a;
    #1;
    checks++;
    if (regRdData !== modelRead(a)) begin
      fails++;
      $display("FAIL %s read addr %0d: got %h expected %h", req, a, regRdData, modelRead(a));
    end
    @(negedge clk); #1;
    regRdEn = 0;
  endtask

  task automatic serPulse();
    @(negedge clk); #1; serClk = 1;
    repeat (HALF_SER) @(negedge clk);
    #1; serClk = 0;
    repeat (HALF_SER) @(negedge clk);
  endtask

  // benchDrives: bench acts as sending master; peerAck: bench acknowledges
  task automatic runFrame(input logic [31:0] msg, input logic benchDrives, input logic peerAck);
    if (benchDrives) peerLow = !msg[31];
    serPulse();
    regRead(3'd6, "R3");                 // R3: shifting phase code
    for (int i = 31; i >= 0; i--) begin
      if (benchDrives) peerLow = !msg[i];
      serPulse();
    end
    peerLow = 0;
    regRead(3'd6, "R3");                 // R3: release phase code
    serPulse();
    regRead(3'd6, "R3");                 // R3: acknowledge phase code
    peerLow = peerAck;
    serPulse();
    peerLow = 0;
    regRead(3'd6, "R3");                 // R3: report phase code
    serPulse();
    regRead(3'd6, "R3");                 // R3: back to start
  endtask

  task automatic readAll(input string req);
    for (int a = 0; a < 4; a++) regRead(3'(a), req);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    // R1: reset state of every register
    for (int a = 0; a < 7; a++) regRead(3'(a), "R1");

    // R2 R5 R7: addressed listener (address 5) receives and acknowledges
    regWrite(3'd4, 8'h05);
    regRead(3'd4, "R12");
    runFrame(32'hA1B2_C3D4, 1'b1, 1'b0);
    readAll("R2");
    regRead(3'd5, "R7");
    regRead(3'd3, "R8");                 // R8: this read clears read-pending
    regRead(3'd5, "R8");

    // R5: address mismatch, no acknowledge and no pending flag
    regWrite(3'd4, 8'h02);
    runFrame(32'hB7E1_5A0F, 1'b1, 1'b0);
    readAll("R2");
    regRead(3'd5, "R5");

    // R10: deaf node with a matching preload keeps its contents
    regWrite(3'd0, 8'h11); regWrite(3'd1, 8'h22);
    regWrite(3'd2, 8'h33); regWrite(3'd3, 8'hA4);
    regWrite(3'd4, 8'h0D);
    runFrame(32'h0F0F_5AA5, 1'b1, 1'b0);
    readAll("R10");
    regRead(3'd5, "R10");

    // R4 R6: node as master, peer acknowledges
    regWrite(3'd0, 8'h01); regWrite(3'd1, 8'h96);
    regWrite(3'd2, 8'h3C); regWrite(3'd3, 8'h5A);
    regWrite(3'd4, 8'h17);
    runFrame(32'h0, 1'b0, 1'b1);
    readAll("R4");
    regRead(3'd5, "R6");

    // R6 R9: no acknowledge, flag and interrupt raised, then cleared by write
    regWrite(3'd3, 8'hC3);
    runFrame(32'h0, 1'b0, 1'b0);
    regRead(3'd5, "R6");
    regWrite(3'd5, 8'h01);
    regRead(3'd5, "R9");

    // R12: control fields read back
    regWrite(3'd4, 8'h0A);
    regRead(3'd4, "R12");

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule